// File: doc/BRIEF.md
# Square-Root-Free Layer Bound Unit

This block serves one layer of a depth-first lattice search for a multi-antenna receiver. For a given layer it finds the range of admissible symbol indices without taking a square root. It evaluates the partial metric for every symbol of a scaled pulse-amplitude constellation, which is fixed when the block is built. It then compares each metric against the squared radius and reduces the results to an upper bound and a starting index. The search controller that drives the block increments the starting index once to land on the best symbol, and walks upward until it passes the upper bound.

The default constellation has four levels at a scale of 128. Symbol index k carries the value (3 - 2k) * 128, so index 0 = 384, 1 = 128, 2 = -128 and 3 = -384, from largest to smallest. For symbol x the metric is p = q * (S - x)^2 + T. Here q is the unsigned diagonal coefficient, S is the signed layer centre term, and T is the unsigned sum already spent by the fixed layers. A symbol is admissible when p <= C, where C is the unsigned squared radius.

Both sides of the block use valid/ready streaming. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the result and its fields hold. If the internal stage is also occupied, `in_ready` drops in the same cycle, so back-pressure reaches the source without loss.

Top module: `sqfree_layer_bound`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: Symbol x is admissible exactly when q*(S-x)^2 + T <= C, with the equality case admissible.
- R3: When at least one symbol is admissible, `bound_hi` is the largest admissible symbol value.
- R4: When at least one symbol is admissible, `start_idx` is the value of the admissible symbol with the smallest metric, minus 128 (one increment step).
- R5: Among admissible symbols with equal smallest metric, the one with the lower index (the larger value) sets `start_idx`.
- R6: When no symbol is admissible, `empty` is 1, `bound_hi` = 384 and `start_idx` = -384; otherwise `empty` is 0.
- R7: With `out_ready` high, the result of a request taken on an edge appears as `out_valid` high two clock cycles later, and not one cycle later.
- R8: While `out_valid` is high and `out_ready` is low, the outputs hold their value. When both stages hold results, `in_ready` is low. Stalled results are then delivered in order.
- R9: Metrics are computed at full width with no wrap, for the extreme values q = 65535, S = -32768, and T and C both equal to 2^32-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request this cycle |
| q_coef | input | 16 | Unsigned diagonal coefficient q |
| s_val | input | 16 | Signed layer centre term S |
| t_acc | input | 32 | Unsigned accumulated metric of fixed layers T |
| c_rad | input | 32 | Unsigned squared radius C |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| bound_hi | output | 18 | Signed upper bound L |
| start_idx | output | 18 | Signed starting index u |
| empty | output | 1 | No symbol lies inside the sphere |

## Verification
On every cycle, the assertions check four things. A stalled result stays frozen. A new result appears only two cycles after an accepted request. An empty result carries the fixed fill values. A non-empty start index never lies above the upper bound. Only the directed scenarios can show the arithmetic itself: that the inclusive boundary is drawn exactly, that ties go to the larger symbol, that the extreme operands do not wrap, and that results stalled behind back-pressure come out in order with the right values.

// File: rtl/slb_pkg.sv
package slb_pkg;
  // Value of symbol k in a scaled PAM set ordered from largest to smallest.
  function automatic int sym_of(input int k, input int nsym, input int scale);
    return (nsym - 1 - 2 * k) * scale;
  endfunction
endpackage

// File: rtl/slb_metric.sv
module slb_metric #(
  parameter int QW   = 16,
  parameter int SW   = 16,
  parameter int TW   = 32,
  parameter int PW   = 51,
  parameter int SYMV = 0
) (
  input  logic [QW-1:0]        q_in,
  input  logic signed [SW-1:0] s_in,
  input  logic [TW-1:0]        t_in,
  output logic [PW-1:0]        p_out
);
  localparam int DW   = SW + 1;
  localparam int SQW  = 2 * DW;
  localparam int PRW  = QW + SQW;
  localparam logic signed [DW-1:0] DX = DW'(SYMV);

  logic signed [DW-1:0] sx;
  logic signed [DW-1:0] diff;
  logic [DW-1:0]        mag;
  logic [SQW-1:0]       sq;
  logic [PRW-1:0]       prod;

  assign sx   = {s_in[SW-1], s_in};
  assign diff = sx - DX;
  // Magnitude before squaring keeps the rest of the path unsigned.
  assign mag  = diff[DW-1] ? (DW'(0) - diff) : diff;
  assign sq   = SQW'(mag) * SQW'(mag);
  assign prod = PRW'(q_in) * PRW'(sq);
  assign p_out = PW'(prod) + PW'(t_in);
endmodule

// File: rtl/slb_pick.sv
module slb_pick
  import slb_pkg::*;
#(
  parameter int NSYM  = 4,
  parameter int SCALE = 128,
  parameter int STEP  = 128,
  parameter int PW    = 51,
  parameter int OW    = 18
) (
  input  logic [PW-1:0]        p_in [NSYM],
  input  logic [NSYM-1:0]      ok_in,
  output logic signed [OW-1:0] hi_out,
  output logic signed [OW-1:0] st_out,
  output logic                 empty_out
);
  localparam int XMAX = sym_of(0, NSYM, SCALE);
  localparam int XMIN = sym_of(NSYM - 1, NSYM, SCALE);

  logic          found;
  int            best;
  logic [PW-1:0] best_p;

  always_comb begin
    found  = 1'b0;
    best   = 0;
    best_p = '1;
    hi_out = OW'(XMAX);
    for (int k = 0; k < NSYM; k++) begin
      if (ok_in[k]) begin
        // Symbols descend with index: first admissible one is the largest.
        if (!found) hi_out = OW'(sym_of(k, NSYM, SCALE));
        // Strict compare keeps the lower index on equal metrics.
        if (!found || (p_in[k] < best_p)) begin
          best   = k;
          best_p = p_in[k];
        end
        found = 1'b1;
      end
    end
    empty_out = !found;
    if (found) st_out = OW'(sym_of(best, NSYM, SCALE) - STEP);
    else       st_out = OW'(XMIN);
  end
endmodule

// File: rtl/sqfree_layer_bound.sv
module sqfree_layer_bound
  import slb_pkg::*;
#(
  parameter int NSYM  = 4,
  parameter int SCALE = 128,
  parameter int STEP  = 128,
  parameter int QW    = 16,
  parameter int SW    = 16,
  parameter int TW    = 32,
  parameter int CW    = 32,
  parameter int OW    = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [QW-1:0]        q_coef,
  input  logic signed [SW-1:0] s_val,
  input  logic [TW-1:0]        t_acc,
  input  logic [CW-1:0]        c_rad,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [OW-1:0] bound_hi,
  output logic signed [OW-1:0] start_idx,
  output logic                 empty
);
  localparam int PROD_W = QW + 2 * (SW + 1);
  localparam int PW     = ((PROD_W > TW) ? PROD_W : TW) + 1;
  localparam int CMPW   = (PW > CW) ? PW : CW;

  logic [PW-1:0]   p_w   [NSYM];
  logic [NSYM-1:0] ok_w;
  logic [PW-1:0]   s1_p  [NSYM];
  logic [NSYM-1:0] s1_ok;
  logic            s1_valid;
  logic            adv2;
  logic            adv1;

  logic signed [OW-1:0] hi_w;
  logic signed [OW-1:0] st_w;
  logic                 empty_w;

  for (genvar k = 0; k < NSYM; k++) begin : g_sym
    slb_metric #(
      .QW(QW), .SW(SW), .TW(TW), .PW(PW),
      .SYMV(sym_of(k, NSYM, SCALE))
    ) u_metric (
      .q_in (q_coef),
      .s_in (s_val),
      .t_in (t_acc),
      .p_out(p_w[k])
    );
    assign ok_w[k] = CMPW'(p_w[k]) <= CMPW'(c_rad);
  end

  assign adv2     = !out_valid || out_ready;
  assign adv1     = !s1_valid || adv2;
  assign in_ready = adv1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_ok    <= '0;
      for (int k = 0; k < NSYM; k++) s1_p[k] <= '0;
    end else if (adv1) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_ok <= ok_w;
        for (int k = 0; k < NSYM; k++) s1_p[k] <= p_w[k];
      end
    end
  end

  slb_pick #(
    .NSYM(NSYM), .SCALE(SCALE), .STEP(STEP), .PW(PW), .OW(OW)
  ) u_pick (
    .p_in     (s1_p),
    .ok_in    (s1_ok),
    .hi_out   (hi_w),
    .st_out   (st_w),
    .empty_out(empty_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      bound_hi  <= '0;
      start_idx <= '0;
      empty     <= 1'b0;
    end else if (adv2) begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        bound_hi  <= hi_w;
        start_idx <= st_w;
        empty     <= empty_w;
      end
    end
  end
endmodule

// File: rtl/sqfree_layer_bound_chk.sv
module sqfree_layer_bound_chk #(
  parameter int OW   = 18,
  parameter int XMAX = 384,
  parameter int XMIN = -384,
  parameter int STEP = 128
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [OW-1:0] bound_hi,
  input logic signed [OW-1:0] start_idx,
  input logic                 empty
);
  a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(bound_hi) && $stable(start_idx) && $stable(empty));

  a_r7_two_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready, 2));

  a_r6_empty_fill: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && empty |-> (bound_hi == OW'(XMAX)) && (start_idx == OW'(XMIN)));

  a_r4_start_below_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !empty |-> (int'(bound_hi) >= int'(start_idx) + STEP));
endmodule

bind sqfree_layer_bound sqfree_layer_bound_chk #(
  .OW  (OW),
  .XMAX(slb_pkg::sym_of(0, NSYM, SCALE)),
  .XMIN(slb_pkg::sym_of(NSYM - 1, NSYM, SCALE)),
  .STEP(STEP)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .bound_hi (bound_hi),
  .start_idx(start_idx),
  .empty    (empty)
);

// File: tb/sim_sqfree_layer_bound.sv
module sim_sqfree_layer_bound;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [15:0]        q_coef = '0;
  logic signed [15:0] s_val = '0;
  logic [31:0]        t_acc = '0;
  logic [31:0]        c_rad = '0;
  logic               out_valid;
  logic               out_ready = 1'b1;
  logic signed [17:0] bound_hi;
  logic signed [17:0] start_idx;
  logic               empty;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sqfree_layer_bound u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .q_coef(q_coef), .s_val(s_val), .t_acc(t_acc), .c_rad(c_rad),
    .out_valid(out_valid), .out_ready(out_ready),
    .bound_hi(bound_hi), .start_idx(start_idx), .empty(empty)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected result from the requirements: symbols 384,128,-128,-384, step 128.
  task automatic model(input longint q, input longint s, input longint t, input longint c,
                       output bit emp, output longint lo_hi, output longint st);
    bit     f = 1'b0;
    int     best = -1;
    longint bp = 0;
    lo_hi = 384;
    st = -384;
    for (int k = 0; k < 4; k++) begin
      longint x = 384 - 256 * k;
      longint d = s - x;
      longint p = q * d * d + t;
      if (p <= c) begin
        if (!f) lo_hi = x;
        f = 1'b1;
        if (best < 0 || p < bp) begin best = k; bp = p; end
      end
    end
    emp = (best < 0);
    if (best >= 0) st = (384 - 256 * best) - 128;
  endtask

  task automatic drive(input longint q, input longint s, input longint t, input longint c);
    q_coef = 16'(q); s_val = 16'(s); t_acc = 32'(t); c_rad = 32'(c);
    in_valid = 1'b1;
  endtask

  task automatic check_out(input string tag, input longint q, input longint s,
                           input longint t, input longint c);
    bit e; longint l; longint u;
    model(q, s, t, c, e, l, u);
    check(out_valid == 1'b1, {tag, " valid"}, out_valid, 1);
    check(empty == e, {tag, " empty"}, empty, e);
    check(bound_hi == l, {tag, " bound_hi"}, bound_hi, l);
    check(start_idx == u, {tag, " start_idx"}, start_idx, u);
  endtask

  // One request with out_ready high; result expected two cycles after acceptance.
  task automatic run_case(input string tag, input longint q, input longint s,
                          input longint t, input longint c);
    out_ready = 1'b1;
    drive(q, s, t, c);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, {tag, " R7 not after one cycle"}, out_valid, 0);
    @(negedge clk);
    check_out(tag, q, s, t, c);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_backpressure;
    out_ready = 1'b0;
    drive(1, -384, 0, 70000);
    @(posedge clk);
    @(negedge clk);
    drive(1, 384, 50000, 60000);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R8 in_ready low when full", in_ready, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_out("R8 held result A", 1, -384, 0, 70000);
    end
    out_ready = 1'b1;
    check_out("R8 result A on release", 1, -384, 0, 70000);
    @(negedge clk);
    check_out("R8 result B in order", 1, 384, 50000, 60000);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 drained", out_valid, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    @(negedge clk);
    run_case("R3 R4 two admissible", 1, -384, 0, 70000);
    run_case("R2 boundary equal", 1, -384, 0, 65536);
    run_case("R2 boundary just below", 1, -384, 0, 65535);
    run_case("R5 tie centre", 1, 0, 0, 20000);
    run_case("R6 empty sphere", 1, 0, 0, 100);
    run_case("R2 T excludes", 1, 384, 50000, 60000);
    run_case("R3 all inside", 2, 100, 7, 4000000);
    run_case("R9 huge metric", 65535, -32768, 0, 64'hFFFF_FFFF);
    run_case("R9 R5 max T equals C", 0, 5, 64'hFFFF_FFFF, 64'hFFFF_FFFF);
    t_backpressure();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule